// File: doc/BRIEF.md
# Flash Access FIFO Controller

This block sits between a host register port and a configuration flash. It holds a word FIFO that carries data in both directions. For a read, the host loads a flash byte address, then writes a control word that asks for a number of 32-bit words. The block fetches those words one after another from a generic flash read port into the FIFO and keeps a busy flag raised until the last word has arrived. The host then drains the FIFO through a data window and writes zero to the control register to return the block to idle.

For a write, the host sets write mode in the control register and pushes words into the data window. The block passes each queued word to a generic flash write port at consecutive addresses. A field in the control register gives the free FIFO space in words. The host polls this field for flow control and waits until the FIFO is completely empty before it sends the next chunk. Any start address outside the valid flash range sets a sticky error bit, and nothing is sent to the flash.

Top module: `flash_fifo_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0000_2000 (free space 512, every other field 0), the address register reads 0, the data window reads 0, and no flash request is made.
- R2: The register at byte offset 0x44 holds the flash start address and reads back the value last written.
- R3: A write to the control register (offset 0x40) with bit 1 set and a word count N in bits 25:16 raises busy (bit 2) from the next cycle. The block then issues exactly N flash reads at the start address and at each following +4 step, and clears busy once word N is in the FIFO. Bit 1 then reads 1. If bits 0 and 1 are both set, the request is treated as a read.
- R4: Each host read of the data window (offset 0x800) returns the next fetched word in fetch order and removes it from the FIFO.
- R5: A data window read while the FIFO is empty returns 0 and leaves the free-space field unchanged.
- R6: A write of zero to the control register discards all queued words and stops any fetch. From the next cycle, busy is 0, both mode bits are 0 and the free space is 512.
- R7: If a read request would touch a byte outside 0x10000..0xC7FFFFF, or a write-mode start address lies outside that range, bit 31 is set. The request makes no flash access and does not enter its mode. Bit 31 stays set until reset, including through later control writes.
- R8: While bit 0 (write mode) is set, each data window write queues one word. Queued words go to the flash write port in order, one per accepted handshake, at the start address and then +4 for each word.
- R9: Control bits 13:4 always read 512 minus the number of queued words.
- R10: A read count above 512 is served as 512 words. A read request with count 0 makes no flash access and leaves busy at 0.
- R11: A data window write outside write mode queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe (pops the FIFO at the data window) |
| hostAddr | input | 12 | Host register byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid in the same cycle as the strobe |
| flashRdReq | output | 1 | One-cycle flash word read request |
| flashRdAddr | output | 32 | Flash byte address of the current read |
| flashRdValid | input | 1 | Flash read data valid |
| flashRdData | input | 32 | Flash read data |
| flashWrReq | output | 1 | Flash word write request, held until accepted |
| flashWrAddr | output | 32 | Flash byte address of the current write |
| flashWrData | output | 32 | Flash write data |
| flashWrReady | input | 1 | Flash accepts the write word this cycle |

## Verification
The FIFO occupancy is visible at every cycle through the free-space field, and the state of the fetch is visible through busy. A wrong pointer or counter therefore shows up in the next control read as a bad free count, or in the next data window read as a word out of order. A fetch sequencer that loses its place shows up within one request as a wrong flash address or count. Errors in range checking or stickiness appear at the first control read after the bad request, as a set or missing bit 31 together with an unexpected flash access.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] CTRL_OFS = 12'h040;
  localparam logic [REG_AW-1:0] ADDR_OFS = 12'h044;
  localparam logic [REG_AW-1:0] DATA_OFS = 12'h800;

  localparam int WR_BIT   = 0;
  localparam int RD_BIT   = 1;
  localparam int BUSY_BIT = 2;
  localparam int FREE_LSB = 4;
  localparam int CNT_LSB  = 16;
  localparam int ERR_BIT  = 31;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic addrRegWr;
    logic loadPtr;
    logic stepPtr;
    logic hostPush;
    logic flashPush;
    logic pop;
    logic flush;
  } fifoCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_WRITE
  } ctrlState_t;
endpackage

// File: rtl/ffc_datapath.sv
module ffc_datapath
  import ffc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] flashRdata,
  output logic [ADDR_W-1:0] addrReg,
  output logic [ADDR_W-1:0] flashPtr,
  output logic [DATA_W-1:0] head,
  output logic [OCC_W-1:0]  occ,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush;
  logic [DATA_W-1:0] pushData;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush   = cmd.hostPush | cmd.flashPush;
  assign pushData = cmd.hostPush ? hostWdata : flashRdata;
  assign head     = mem[rdPtr];
  assign empty    = (occ == '0);
  assign full     = (occ == OCC_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (doPush && !cmd.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (doPush)  wrPtr <= nextPtr(wrPtr);
      if (cmd.pop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, cmd.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      flashPtr <= '0;
    end else begin
      if (cmd.addrRegWr) addrReg <= ADDR_W'(hostWdata);
      if (cmd.loadPtr)      flashPtr <= addrReg;
      else if (cmd.stepPtr) flashPtr <= flashPtr + ADDR_W'(4);
    end
  end
endmodule

// File: rtl/ffc_ctrl.sv
module ffc_ctrl
  import ffc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 512,
  parameter int CNT_W  = 10,
  parameter int FREE_W = 10,
  parameter logic [ADDR_W-1:0] FLASH_MIN = 'h0001_0000,
  parameter logic [ADDR_W-1:0] FLASH_MAX = 'h0C7F_FFFF,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              flashRdValid,
  input  logic              flashWrReady,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [OCC_W-1:0]  occ,
  input  logic              empty,
  input  logic              full,
  output fifoCmd_t          cmd,
  output logic              flashRdReq,
  output logic              flashWrReq,
  output logic              busy,
  output logic              wrMode,
  output logic              errFlag,
  output logic [FREE_W-1:0] freeWords,
  output logic [DATA_W-1:0] ctrlWord
);
  ctrlState_t       state;
  logic             rdMode;
  logic [CNT_W-1:0] cntReg;
  logic [OCC_W-1:0] remaining;

  logic             ctrlWr, winWr, winRd, wantRd, wantWr;
  logic [CNT_W-1:0] cntField;
  logic [OCC_W-1:0] clampCnt;
  logic [ADDR_W:0]  lastByte;
  logic             rdOk, wrOk, startRd, startWr, wrTake;

  assign ctrlWr   = hostWr && (hostAddr == CTRL_OFS);
  assign winWr    = hostWr && (hostAddr == DATA_OFS);
  assign winRd    = hostRd && (hostAddr == DATA_OFS);
  assign wantRd   = hostWdata[RD_BIT];
  assign wantWr   = hostWdata[WR_BIT];
  assign cntField = hostWdata[CNT_LSB +: CNT_W];
  assign clampCnt = (32'(cntField) > 32'(DEPTH)) ? OCC_W'(DEPTH) : OCC_W'(cntField);

  // last byte touched by the burst, one bit wider so it cannot wrap
  assign lastByte = {1'b0, addrReg} + ((ADDR_W + 1)'(clampCnt) << 2) - (ADDR_W + 1)'(1);
  assign rdOk     = (addrReg >= FLASH_MIN) && (lastByte <= {1'b0, FLASH_MAX});
  assign wrOk     = (addrReg >= FLASH_MIN) && (addrReg <= FLASH_MAX);
  assign startRd  = wantRd && (clampCnt != '0) && rdOk;
  assign startWr  = !wantRd && wantWr && wrOk;

  assign busy       = (state == ST_RD_ISSUE) || (state == ST_RD_WAIT);
  assign wrMode     = (state == ST_WRITE);
  assign flashRdReq = (state == ST_RD_ISSUE);
  assign flashWrReq = wrMode && !empty;
  assign wrTake     = flashWrReq && flashWrReady;
  assign freeWords  = FREE_W'(DEPTH) - FREE_W'(occ);

  always_comb begin
    cmd           = '0;
    cmd.addrRegWr = hostWr && (hostAddr == ADDR_OFS);
    cmd.flush     = ctrlWr;
    cmd.loadPtr   = ctrlWr && (startRd || startWr);
    cmd.hostPush  = winWr && wrMode && !full && !ctrlWr;
    cmd.flashPush = (state == ST_RD_WAIT) && flashRdValid && !ctrlWr;
    cmd.pop       = (winRd && !wrMode && !empty) || wrTake;
    cmd.stepPtr   = !ctrlWr && (cmd.flashPush || wrTake);
  end

  always_comb begin
    ctrlWord                       = '0;
    ctrlWord[WR_BIT]               = wrMode;
    ctrlWord[RD_BIT]               = rdMode;
    ctrlWord[BUSY_BIT]             = busy;
    ctrlWord[FREE_LSB +: FREE_W]   = freeWords;
    ctrlWord[CNT_LSB +: CNT_W]     = cntReg;
    ctrlWord[ERR_BIT]              = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rdMode    <= 1'b0;
      cntReg    <= '0;
      remaining <= '0;
      errFlag   <= 1'b0;
    end else if (ctrlWr) begin
      cntReg <= cntField;
      if (wantRd) begin
        if (clampCnt == '0) begin
          state  <= ST_IDLE;
          rdMode <= 1'b1;
        end else if (!rdOk) begin
          state   <= ST_IDLE;
          rdMode  <= 1'b0;
          errFlag <= 1'b1;
        end else begin
          state     <= ST_RD_ISSUE;
          rdMode    <= 1'b1;
          remaining <= clampCnt;
        end
      end else if (wantWr) begin
        rdMode <= 1'b0;
        if (wrOk) state <= ST_WRITE;
        else begin
          state   <= ST_IDLE;
          errFlag <= 1'b1;
        end
      end else begin
        state  <= ST_IDLE;
        rdMode <= 1'b0;
      end
    end else begin
      case (state)
        ST_RD_ISSUE: state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (flashRdValid) begin
            remaining <= remaining - 1'b1;
            state     <= (remaining == OCC_W'(1)) ? ST_IDLE : ST_RD_ISSUE;
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/flash_fifo_ctrl.sv
module flash_fifo_ctrl
  import ffc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 512,
  parameter int CNT_W  = 10,
  parameter logic [ADDR_W-1:0] FLASH_MIN = 'h0001_0000,
  parameter logic [ADDR_W-1:0] FLASH_MAX = 'h0C7F_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              flashRdReq,
  output logic [ADDR_W-1:0] flashRdAddr,
  input  logic              flashRdValid,
  input  logic [DATA_W-1:0] flashRdData,
  output logic              flashWrReq,
  output logic [ADDR_W-1:0] flashWrAddr,
  output logic [DATA_W-1:0] flashWrData,
  input  logic              flashWrReady
);
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int FREE_W = OCC_W;

  fifoCmd_t          cmd;
  logic [ADDR_W-1:0] addrReg, flashPtr;
  logic [DATA_W-1:0] head, ctrlWord;
  logic [OCC_W-1:0]  occ;
  logic              empty, full, busy, wrMode, errFlag;
  logic [FREE_W-1:0] freeWords;

  ffc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .FREE_W(FREE_W), .FLASH_MIN(FLASH_MIN), .FLASH_MAX(FLASH_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .flashRdValid(flashRdValid), .flashWrReady(flashWrReady),
    .addrReg(addrReg), .occ(occ), .empty(empty), .full(full),
    .cmd(cmd), .flashRdReq(flashRdReq), .flashWrReq(flashWrReq),
    .busy(busy), .wrMode(wrMode), .errFlag(errFlag),
    .freeWords(freeWords), .ctrlWord(ctrlWord)
  );

  ffc_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWdata(hostWdata),
    .flashRdata(flashRdData), .addrReg(addrReg), .flashPtr(flashPtr),
    .head(head), .occ(occ), .empty(empty), .full(full)
  );

  assign flashRdAddr = flashPtr;
  assign flashWrAddr = flashPtr;
  assign flashWrData = head;

  always_comb begin
    case (hostAddr)
      CTRL_OFS: hostRdata = ctrlWord;
      ADDR_OFS: hostRdata = DATA_W'(addrReg);
      DATA_OFS: hostRdata = (!wrMode && !empty) ? head : '0;
      default:  hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker
  import ffc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int FREE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic [REG_AW-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              flashRdReq,
  input logic              flashWrReq,
  input logic              busy,
  input logic              wrMode,
  input logic              errFlag,
  input logic [FREE_W-1:0] freeWords
);
  // R3
  rd_req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashRdReq |-> busy);

  // R3
  busy_from_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWr && (hostAddr == CTRL_OFS) && hostWdata[RD_BIT]));

  // R8
  wr_req_in_wrmode_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWrReq |-> wrMode);

  // R9
  free_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeWords <= FREE_W'(DEPTH));

  // R6
  zero_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && (hostAddr == CTRL_OFS) && (hostWdata == '0))
      |=> (freeWords == FREE_W'(DEPTH) && !busy && !wrMode));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind flash_fifo_ctrl ffc_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .FREE_W(FREE_W)
) u_ffc_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .flashRdReq(flashRdReq), .flashWrReq(flashWrReq),
  .busy(busy), .wrMode(wrMode), .errFlag(errFlag), .freeWords(freeWords)
);

// File: tb/test_flash_fifo_ctrl.sv
module test_flash_fifo_ctrl;
  localparam logic [11:0] CTRL = 12'h040;
  localparam logic [11:0] ADDR = 12'h044;
  localparam logic [11:0] WIN  = 12'h800;
  localparam int NVEC = 4;
  // {start address, word count}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0001_0000, 16'd4},
    {32'h0002_0040, 16'd1},
    {32'h0C7F_FFF0, 16'd4},
    {32'h0001_0100, 16'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        flashRdReq, flashWrReq;
  logic [31:0] flashRdAddr, flashWrAddr, flashWrData;
  logic        flashRdValid = 1'b0;
  logic [31:0] flashRdData = '0;
  logic        flashWrReady = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int          rdReqCount = 0, wrCount = 0;
  logic [31:0] rdLog [2048];
  logic [31:0] wrAddrLog [16];
  logic [31:0] wrDataLog [16];
  logic        rdPend = 1'b0;
  logic [31:0] rdPendAddr = '0;

  always #2.5 clk = ~clk;

  flash_fifo_ctrl i_flash_fifo_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .flashRdReq(flashRdReq), .flashRdAddr(flashRdAddr),
    .flashRdValid(flashRdValid), .flashRdData(flashRdData),
    .flashWrReq(flashWrReq), .flashWrAddr(flashWrAddr),
    .flashWrData(flashWrData), .flashWrReady(flashWrReady)
  );

  function automatic logic [31:0] flashWord(input logic [31:0] a);
    return (a * 32'h0001_0001) ^ 32'hC3C3_3C3C;
  endfunction

  // flash model: two-cycle read latency, logs every request
  always @(posedge clk) begin
    rdPend       <= flashRdReq;
    rdPendAddr   <= flashRdAddr;
    flashRdValid <= rdPend;
    flashRdData  <= flashWord(rdPendAddr);
    if (flashRdReq) begin
      if (rdReqCount < 2048) rdLog[rdReqCount] <= flashRdAddr;
      rdReqCount <= rdReqCount + 1;
    end
    if (flashWrReq && flashWrReady) begin
      if (wrCount < 16) begin
        wrAddrLog[wrCount] <= flashWrAddr;
        wrDataLog[wrCount] <= flashWrData;
      end
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; hostWdata = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    hostRd = 1'b1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic waitIdle(output bit ok);
    logic [31:0] c;
    ok = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      busRead(CTRL, c);
      if (!c[2]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] ctrlVal(input bit err, input int cnt, input int free,
                                          input bit bsy, input bit rd, input bit wr);
    return {err, 5'b0, 10'(cnt), 2'b0, 10'(free), 1'b0, bsy, rd, wr};
  endfunction

  initial begin
    repeat (1500000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(CTRL, d); check("R1 ctrl", d, 32'h0000_2000);
    busRead(ADDR, d); check("R1 addr", d, 32'h0);
    busRead(WIN, d);  check("R1 window", d, 32'h0);
    check("R1 no flash request", 32'(rdReqCount), 32'd0);

    // R5 empty window read
    busRead(WIN, d);  check("R5 empty read zero", d, 32'h0);
    busRead(CTRL, d); check("R5 free unchanged", d, 32'h0000_2000);

    // R2 address register
    busWrite(ADDR, 32'h0001_2340);
    busRead(ADDR, d); check("R2 addr readback", d, 32'h0001_2340);

    // vector table: read bursts (R3, R4, R9)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] a;
      int n;
      a = VEC[v][47:16];
      n = int'(VEC[v][15:0]);
      base = rdReqCount;
      busWrite(ADDR, a);
      busWrite(CTRL, (32'(n) << 16) | 32'h2);
      busRead(CTRL, d); check("R3 busy after request", 32'(d[2]), 32'd1);
      waitIdle(ok); check("R3 busy clears", 32'(ok), 32'd1);
      check("R3 request count", 32'(rdReqCount - base), 32'(n));
      for (int i = 0; i < n; i++)
        check("R3 flash address", rdLog[base + i], a + 32'(4 * i));
      busRead(CTRL, d); check("R9 free after fill", d, ctrlVal(0, n, 512 - n, 0, 1, 0));
      for (int i = 0; i < n; i++) begin
        busRead(WIN, d); check("R4 window data", d, flashWord(a + 32'(4 * i)));
      end
      busRead(CTRL, d); check("R9 free after drain", d, ctrlVal(0, n, 512, 0, 1, 0));
      busWrite(CTRL, 32'h0);
    end

    // R6 flush in the middle of a drain
    busWrite(ADDR, 32'h0003_0000);
    busWrite(CTRL, (32'd8 << 16) | 32'h2);
    waitIdle(ok);
    busRead(WIN, d); check("R4 first word", d, flashWord(32'h0003_0000));
    busRead(WIN, d); check("R4 second word", d, flashWord(32'h0003_0004));
    busWrite(CTRL, 32'h0);
    busRead(CTRL, d); check("R6 idle after zero", d, 32'h0000_2000);
    busRead(WIN, d);  check("R6 queue discarded", d, 32'h0);

    // R10 count zero
    base = rdReqCount;
    busWrite(CTRL, 32'h2);
    busRead(CTRL, d); check("R10 count zero no busy", d, ctrlVal(0, 0, 512, 0, 1, 0));
    repeat (5) @(negedge clk);
    check("R10 count zero no access", 32'(rdReqCount - base), 32'd0);

    // R10 clamp to 512
    base = rdReqCount;
    busWrite(ADDR, 32'h0001_0000);
    busWrite(CTRL, (32'h3FF << 16) | 32'h2);
    waitIdle(ok); check("R10 clamp completes", 32'(ok), 32'd1);
    check("R10 clamp count", 32'(rdReqCount - base), 32'd512);
    check("R10 clamp last addr", rdLog[base + 511], 32'h0001_0000 + 32'd2044);
    busRead(CTRL, d); check("R9 full fifo", d, ctrlVal(0, 32'h3FF, 0, 0, 1, 0));
    busWrite(CTRL, 32'h0);
    busRead(CTRL, d); check("R6 flush full fifo", d, 32'h0000_2000);

    // R3 both mode bits: read wins
    base = rdReqCount;
    busWrite(ADDR, 32'h0004_0000);
    busWrite(CTRL, (32'd1 << 16) | 32'h3);
    waitIdle(ok);
    check("R3 both bits read count", 32'(rdReqCount - base), 32'd1);
    busRead(CTRL, d); check("R3 both bits ctrl", d, ctrlVal(0, 1, 511, 0, 1, 0));
    busWrite(CTRL, 32'h0);

    // R11 window write outside write mode
    busWrite(WIN, 32'h1234_5678);
    busRead(CTRL, d); check("R11 nothing queued", d, 32'h0000_2000);
    busRead(WIN, d);  check("R11 window still empty", d, 32'h0);

    // R8 write mode
    flashWrReady = 1'b0;
    busWrite(ADDR, 32'h0002_0000);
    busWrite(CTRL, 32'h1);
    busWrite(WIN, 32'hAAAA_0001);
    busWrite(WIN, 32'hBBBB_0002);
    busWrite(WIN, 32'hCCCC_0003);
    busRead(WIN, d);  check("R8 window read in write mode", d, 32'h0);
    busRead(CTRL, d); check("R9 free during write", d, ctrlVal(0, 0, 509, 0, 0, 1));
    check("R8 write request pending", 32'(flashWrReq), 32'd1);
    flashWrReady = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 write count", 32'(wrCount), 32'd3);
    check("R8 addr 0", wrAddrLog[0], 32'h0002_0000);
    check("R8 addr 2", wrAddrLog[2], 32'h0002_0008);
    check("R8 data 0", wrDataLog[0], 32'hAAAA_0001);
    check("R8 data 1", wrDataLog[1], 32'hBBBB_0002);
    check("R8 data 2", wrDataLog[2], 32'hCCCC_0003);
    busRead(CTRL, d); check("R9 empty after forward", d, ctrlVal(0, 0, 512, 0, 0, 1));
    busWrite(CTRL, 32'h0);

    // R7 range errors
    base = rdReqCount;
    busWrite(ADDR, 32'h0000_FFFC);
    busWrite(CTRL, (32'd1 << 16) | 32'h2);
    busRead(CTRL, d); check("R7 low address error", d, ctrlVal(1, 1, 512, 0, 0, 0));
    busWrite(CTRL, 32'h0);
    busRead(CTRL, d); check("R7 error sticky", d, 32'h8000_2000);
    busWrite(ADDR, 32'h0C7F_FFFC);
    busWrite(CTRL, (32'd2 << 16) | 32'h2);
    repeat (6) @(negedge clk);
    busRead(CTRL, d); check("R7 end overrun no busy", 32'(d[2:0]), 32'd0);
    check("R7 no flash read", 32'(rdReqCount - base), 32'd0);
    busWrite(ADDR, 32'h0C80_0000);
    busWrite(CTRL, 32'h1);
    busWrite(WIN, 32'hDEAD_BEEF);
    repeat (4) @(negedge clk);
    busRead(CTRL, d); check("R7 bad write start", d, 32'h8000_2000);
    check("R7 no flash write", 32'(wrCount), 32'd3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule